// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire PHY management interface of IEEE 802.3 clause 22. It generates the management clock from the system clock, drives the data line while it owns it and releases the line to the PHY for the turnaround and data phases of a read. Software programs a clock divider and an optional preamble skip, loads the PHY and register addresses and any write data, and then starts one of three operations: a single read, a single write, or a continuous scan that reads one register again and again.

Software polls a busy bit to see when an operation ends. It then takes the result from a read-data register and returns the command register to zero. The block will not start a new operation until that zero has been seen. In scan mode the block keeps the read-data register and a link-fail flag up to date. A status bit reports that no scan result has arrived yet.

Top module: `mdio_master`

## Requirements
- R1: While reset is held, `mdc` is 0, `mdio_oe` is 0 and the status register reads 0. After reset the control register reads the reset divider (10) with preamble skip 0, and the command register reads 0.
- R2: Register select codes are 0 control, 1 command, 2 address, 3 write data, 4 read data and 5 status. Control keeps bits 8:0. Address keeps the PHY address in bits 4:0 and the register number in bits 12:8. Write data keeps 16 bits. Read data is read-only, so writes to it are ignored. Status bit 0 is link fail, bit 1 is busy and bit 2 is invalid.
- R3: The period of `mdc` is D system clocks, where D is control bits 7:0 with bit 0 cleared. A D below 2 gives a period of 2.
- R4: A write frame on the line is 32 ones of preamble, start 01, opcode 01, five PHY address bits, five register bits, turnaround 10 and 16 data bits, all most significant bit first. The master changes the line only after a falling `mdc` edge, and the line holds steady at each rising edge.
- R5: When control bit 8 is 1, the preamble is left out and the frame begins with the start bits.
- R6: A read frame uses opcode 10. The master releases `mdio_oe` for the two turnaround bits and the 16 data bits. The read-data register then holds the 16 bits sampled on the rising `mdc` edges, most significant bit first.
- R7: Busy reads 0 after the clock edge that stores a command write and reads 1 after the next edge. Busy returns to 0 on the system clock edge that makes the rising `mdc` edge of the last data bit.
- R8: After an operation, a new nonzero value written to the command register starts nothing until the command register has held zero. A write after that zero starts normally.
- R9: Command bit 0 (scan) wins over bit 1 (read), and bit 1 wins over bit 2 (write). Writing 6 runs a read.
- R10: Scan repeats read frames and keeps busy at 1 between them. Invalid is 1 from the start of the scan until the first frame completes. Each completed frame updates read data, and sets link fail to the inverse of bit 2 of the value read. Clearing the command lets the current frame finish, and then busy falls and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 3 | Register select |
| csr_wdata | input | 16 | Register write data |
| csr_rdata | output | 16 | Selected register contents (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Sampled data line |

## Verification
A command starts one clock edge after the edge that stores it, so busy is read once just after the storing edge (expected 0) and once after the following edge (expected 1). Frame results land on the system clock edge that makes the rising `mdc` edge of the last data bit. The frame monitor samples each bit 1 ns after its rising `mdc` edge, and the driver reads busy, status and read data at that same point. The management clock period is measured between consecutive rising edges of `mdc`, counted in system clocks. A scan is checked after each completed frame, and a quiet period after the scan is stopped shows that no extra frame appears.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int MD_AW    = 5;
  localparam int MD_DW    = 16;
  localparam int MD_DIV_W = 8;
  localparam int MD_FRAME = 4 + 2 * MD_AW + 2 + MD_DW;
  localparam int LINK_BIT = 2;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_CMD   = 3'd1,
    SEL_ADDR  = 3'd2,
    SEL_WDATA = 3'd3,
    SEL_RDATA = 3'd4,
    SEL_STAT  = 3'd5
  } csr_sel_e;

  typedef enum logic [1:0] {OP_NONE, OP_SCAN, OP_READ, OP_WRITE} mdio_op_e;

  // system clocks per half period of the management clock
  function automatic logic [MD_DIV_W-1:0] mdc_half(input logic [MD_DIV_W-1:0] div);
    logic [MD_DIV_W-1:0] even;
    even = {div[MD_DIV_W-1:1], 1'b0};
    if (even < MD_DIV_W'(4)) return MD_DIV_W'(1);
    return {1'b0, even[MD_DIV_W-1:1]};
  endfunction

  // lowest set command bit wins
  function automatic mdio_op_e pick_op(input logic [2:0] cmd);
    if (cmd[0]) return OP_SCAN;
    if (cmd[1]) return OP_READ;
    if (cmd[2]) return OP_WRITE;
    return OP_NONE;
  endfunction

  // frame body without preamble, first bit in the MSB
  function automatic logic [MD_FRAME-1:0] build_frame(input logic is_read,
                                                      input logic [MD_AW-1:0] phy,
                                                      input logic [MD_AW-1:0] rga,
                                                      input logic [MD_DW-1:0] wd);
    logic [1:0] opc;
    opc = is_read ? 2'b10 : 2'b01;
    return {2'b01, opc, phy, rga, 2'b10, (is_read ? {MD_DW{1'b0}} : wd)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MD_DIV_W-1:0] div,
  output logic                mdc,
  output logic                rise,
  output logic                fall
);
  logic [MD_DIV_W-1:0] cnt;
  logic [MD_DIV_W-1:0] half;
  logic                term;

  assign half = mdc_half(div);
  assign term = (cnt >= half - MD_DIV_W'(1));
  assign rise = term && !mdc;
  assign fall = term && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + MD_DIV_W'(1);
    end
  end

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise); // R3
endmodule

// File: rtl/mdio_engine.sv
`timescale 1ns/1ps
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_read,
  input  logic             nopre,
  input  logic             again,
  input  logic [MD_AW-1:0] phy,
  input  logic [MD_AW-1:0] rga,
  input  logic [MD_DW-1:0] wdata,
  input  logic             rise,
  input  logic             fall,
  input  logic             mdio_i,
  output logic             mdo,
  output logic             mdoe,
  output logic             busy,
  output logic             done,
  output logic             rd_frame,
  output logic [MD_DW-1:0] rd_word
);
  localparam int PW       = $clog2(PRE_LEN + 1);
  localparam int FW       = $clog2(MD_FRAME + 1);
  localparam int TA_IDX   = 4 + 2 * MD_AW;
  localparam int DATA_IDX = TA_IDX + 2;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_st_e;

  eng_st_e             st;
  logic [MD_FRAME-1:0] sh;
  logic [PW-1:0]       pre_left;
  logic [FW-1:0]       drv_cnt;
  logic [FW-1:0]       smp_cnt;
  logic                rd_q;
  logic [MD_DW-1:0]    cap;

  // named events used by the logic and the assertions
  logic sample_now, load, load_rd, drive_pre, drive_bit, in_turn;

  assign sample_now = (st == ENG_RUN) && rise && (smp_cnt < drv_cnt);
  assign done       = sample_now && (smp_cnt == FW'(MD_FRAME - 1));
  assign load       = ((st == ENG_IDLE) && start) || (done && again);
  assign load_rd    = (st == ENG_IDLE) ? op_read : 1'b1;
  assign drive_pre  = (st == ENG_RUN) && fall && (pre_left != '0);
  assign drive_bit  = (st == ENG_RUN) && fall && (pre_left == '0) && (drv_cnt < FW'(MD_FRAME));
  assign in_turn    = rd_q && (drv_cnt >= FW'(TA_IDX));
  assign rd_word    = {cap[MD_DW-2:0], mdio_i};
  assign busy       = (st == ENG_RUN);
  assign rd_frame   = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ENG_IDLE;
      sh       <= '0;
      pre_left <= '0;
      drv_cnt  <= '0;
      smp_cnt  <= '0;
      rd_q     <= 1'b0;
      cap      <= '0;
      mdo      <= 1'b1;
      mdoe     <= 1'b0;
    end else begin
      if (load) begin
        st       <= ENG_RUN;
        sh       <= build_frame(load_rd, phy, rga, wdata);
        pre_left <= nopre ? '0 : PW'(PRE_LEN);
        drv_cnt  <= '0;
        smp_cnt  <= '0;
        rd_q     <= load_rd;
      end else if (done) begin
        st <= ENG_IDLE;
      end else begin
        if (drive_pre) begin
          mdo      <= 1'b1;
          mdoe     <= 1'b1;
          pre_left <= pre_left - PW'(1);
        end
        if (drive_bit) begin
          mdo     <= sh[MD_FRAME-1];
          sh      <= {sh[MD_FRAME-2:0], 1'b0};
          mdoe    <= !in_turn;
          drv_cnt <= drv_cnt + FW'(1);
        end
        if (sample_now) begin
          smp_cnt <= smp_cnt + FW'(1);
          if (rd_q && (smp_cnt >= FW'(DATA_IDX))) cap <= rd_word;
        end
      end
      // hand the line back one half period after the last bit
      if ((st == ENG_IDLE) && fall) mdoe <= 1'b0;
    end
  end

  AST_LINE_ON_FALL:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(mdo) |-> $past(fall)); // R4
  AST_READ_RELEASED:  assert property (@(posedge clk) disable iff (!rst_n)
                        (busy && rd_q && (drv_cnt > FW'(DATA_IDX))) |-> !mdoe); // R6
  AST_BUSY_END_RISE:  assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(rise)); // R7
endmodule

// File: rtl/mdio_csr.sv
`timescale 1ns/1ps
module mdio_csr
  import mdio_pkg::*;
#(
  parameter logic [MD_DIV_W-1:0] RST_DIV = 8'd10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [2:0]          sel,
  input  logic [15:0]         wdata,
  output logic [15:0]         rdata,
  input  logic                eng_busy,
  input  logic                eng_done,
  input  logic                eng_rd_frame,
  input  logic [MD_DW-1:0]    rd_word,
  output logic                start,
  output logic                op_read,
  output logic                nopre,
  output logic                again,
  output logic [MD_DIV_W-1:0] div,
  output logic [MD_AW-1:0]    phy,
  output logic [MD_AW-1:0]    rga,
  output logic [MD_DW-1:0]    wd
);
  logic [MD_DIV_W:0] ctrl_q;
  logic [2:0]        cmd_q;
  logic              armed_q;
  logic              scan_q;
  logic [MD_DW-1:0]  rdata_q;
  logic              linkfail_q;
  logic              invalid_q;
  mdio_op_e          op;

  assign op      = pick_op(cmd_q);
  assign start   = armed_q && (cmd_q != 3'd0) && !eng_busy;
  assign op_read = (op != OP_WRITE);
  assign again   = scan_q && cmd_q[0];
  assign div     = ctrl_q[MD_DIV_W-1:0];
  assign nopre   = ctrl_q[MD_DIV_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= {1'b0, RST_DIV};
      cmd_q  <= '0;
      phy    <= '0;
      rga    <= '0;
      wd     <= '0;
    end else if (wr) begin
      case (csr_sel_e'(sel))
        SEL_CTRL:  ctrl_q <= wdata[MD_DIV_W:0];
        SEL_CMD:   cmd_q  <= wdata[2:0];
        SEL_ADDR: begin
          phy <= wdata[MD_AW-1:0];
          rga <= wdata[8 +: MD_AW];
        end
        SEL_WDATA: wd <= wdata[MD_DW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b1;
      scan_q     <= 1'b0;
      rdata_q    <= '0;
      linkfail_q <= 1'b0;
      invalid_q  <= 1'b0;
    end else begin
      if (start) armed_q <= 1'b0;
      else if (cmd_q == 3'd0) armed_q <= 1'b1;
      if (start) begin
        scan_q    <= (op == OP_SCAN);
        invalid_q <= (op == OP_SCAN);
      end
      if (eng_done) begin
        invalid_q <= 1'b0;
        if (eng_rd_frame) rdata_q <= rd_word;
        if (scan_q) linkfail_q <= ~rd_word[LINK_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (csr_sel_e'(sel))
      SEL_CTRL:  rdata = 16'(ctrl_q);
      SEL_CMD:   rdata = 16'(cmd_q);
      SEL_ADDR:  rdata = {3'b000, rga, 3'b000, phy};
      SEL_WDATA: rdata = wd;
      SEL_RDATA: rdata = rdata_q;
      SEL_STAT:  rdata = {13'd0, invalid_q, eng_busy, linkfail_q};
      default:   rdata = '0;
    endcase
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> eng_busy); // R7
  AST_REARM_ON_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) $rose(armed_q) |-> $past(cmd_q == 3'd0)); // R8
  AST_SCAN_STAYS_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) (eng_done && again) |=> eng_busy); // R10
  AST_INVALID_ON_DONE:  assert property (@(posedge clk) disable iff (!rst_n) $fell(invalid_q) |-> $past(eng_done)); // R10
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int                  PRE_LEN = 32,
  parameter logic [MD_DIV_W-1:0] RST_DIV = 8'd10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic [2:0]  csr_sel,
  input  logic [15:0] csr_wdata,
  output logic [15:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                start, op_read, nopre, again;
  logic [MD_DIV_W-1:0] div;
  logic [MD_AW-1:0]    phy, rga;
  logic [MD_DW-1:0]    wd, rd_word;
  logic                rise, fall, busy, done, rd_frame;

  mdio_csr #(.RST_DIV(RST_DIV)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr(csr_wr), .sel(csr_sel), .wdata(csr_wdata),
    .rdata(csr_rdata), .eng_busy(busy), .eng_done(done), .eng_rd_frame(rd_frame),
    .rd_word(rd_word), .start(start), .op_read(op_read), .nopre(nopre),
    .again(again), .div(div), .phy(phy), .rga(rga), .wd(wd)
  );

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .div(div), .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read), .nopre(nopre),
    .again(again), .phy(phy), .rga(rga), .wdata(wd), .rise(rise), .fall(fall),
    .mdio_i(mdio_i), .mdo(mdio_o), .mdoe(mdio_oe), .busy(busy), .done(done),
    .rd_frame(rd_frame), .rd_word(rd_word)
  );
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam logic [2:0] S_CTRL = 3'd0, S_CMD = 3'd1, S_ADDR = 3'd2,
                         S_WD = 3'd3, S_RD = 3'd4, S_STAT = 3'd5;

  typedef struct {
    bit          rd;
    logic [4:0]  phy;
    logic [4:0]  rga;
    logic [15:0] data;
    int          pre;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [2:0]  csr_sel = 3'd0;
  logic [15:0] csr_wdata = 16'd0;
  logic [15:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_oe = 1'b0, phy_d = 1'b1;
  wire         mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_d : 1'b1);

  int n_chk = 0, n_err = 0, frames_seen = 0;
  item_t exp_q[$];

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_sel = s; csr_wdata = d;
    @(posedge clk); #1;
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [2:0] s, output logic [15:0] v);
    csr_sel = s; #1;
    v = csr_rdata;
  endtask

  task automatic push(input bit rd, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] d, input int pre, input string tag);
    item_t it;
    it.rd = rd; it.phy = p; it.rga = r; it.data = d; it.pre = pre; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // ---------------- monitor: decodes frames and pops the scoreboard
  logic [31:0] fr = '0;
  int  kcnt = 0, pre_cnt = 0;
  bit  collecting = 0, rd_fr = 0, oe_bad = 0;

  always @(posedge mdc) begin
    #1;
    if (!collecting) begin
      if (mdio_oe && mdio_i) pre_cnt++;
      else if (mdio_oe && !mdio_i) begin
        collecting = 1; fr = '0; kcnt = 1; rd_fr = 0; oe_bad = 0;
      end
    end else begin
      fr = {fr[30:0], mdio_i};
      kcnt++;
      if (kcnt == 4) rd_fr = (fr[1:0] == 2'b10);
      if (rd_fr && kcnt >= 15 && mdio_oe) oe_bad = 1;
      if (kcnt == 32) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected frame", fr, 32'h0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check({it.tag, " header"}, {16'h0, fr[31:16]},
                {16'h0, 2'b01, (it.rd ? 2'b10 : 2'b01), it.phy, it.rga, 2'b10});
          check({it.tag, " data"}, {16'h0, fr[15:0]}, {16'h0, it.data});
          check({it.tag, " preamble"}, pre_cnt, it.pre);
          if (it.rd) check("R6 line released", {31'h0, oe_bad}, 32'h0);
        end
        collecting = 0; pre_cnt = 0;
        frames_seen++;
      end
    end
  end

  // ---------------- PHY model: answers reads with the head item data
  always @(negedge mdc) begin
    #1;
    phy_oe = 1'b0;
    if (collecting && rd_fr && kcnt >= 15 && kcnt <= 31 && exp_q.size() > 0) begin
      phy_oe = 1'b1;
      phy_d  = (kcnt == 15) ? 1'b0 : exp_q[0].data[31 - kcnt];
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  task automatic mdc_period(input string tag, input int exp_cyc);
    longint t0;
    @(posedge mdc); @(posedge mdc);
    t0 = $time;
    @(posedge mdc);
    check(tag, 32'(($time - t0) / 10), 32'(exp_cyc));
  endtask

  task automatic wait_frames(input int n);
    wait (frames_seen == n);
  endtask

  initial begin
    logic [15:0] v;
    int base;
    // R1 reset
    repeat (5) @(posedge clk); #1;
    check("R1 mdc in reset", {31'h0, mdc}, 32'h0);
    check("R1 oe in reset", {31'h0, mdio_oe}, 32'h0);
    csr_read(S_STAT, v); check("R1 status", {16'h0, v}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    csr_read(S_CTRL, v); check("R1 control reset", {16'h0, v}, 32'h000A);
    csr_read(S_CMD, v);  check("R1 command reset", {16'h0, v}, 32'h0);

    // R2 register fields
    csr_write(S_CTRL, 16'hFFFF); csr_read(S_CTRL, v); check("R2 control bits", {16'h0, v}, 32'h01FF);
    csr_write(S_ADDR, 16'hFFFF); csr_read(S_ADDR, v); check("R2 address fields", {16'h0, v}, 32'h1F1F);
    csr_write(S_WD, 16'hBEEF);   csr_read(S_WD, v);   check("R2 write data", {16'h0, v}, 32'hBEEF);
    csr_write(S_RD, 16'hFFFF);   csr_read(S_RD, v);   check("R2 read data read-only", {16'h0, v}, 32'h0);

    // R3 divider
    csr_write(S_CTRL, 16'd8); mdc_period("R3 div 8", 8);
    csr_write(S_CTRL, 16'd9); mdc_period("R3 div 9 odd", 8);
    csr_write(S_CTRL, 16'd0); mdc_period("R3 div 0 minimum", 2);
    csr_write(S_CTRL, 16'd6); mdc_period("R3 div 6", 6);
    csr_write(S_CTRL, 16'd4);

    // R4 write frame + R7 busy timing
    csr_write(S_ADDR, 16'h1105);
    push(0, 5'd5, 5'h11, 16'hBEEF, 32, "R4 write");
    base = frames_seen;
    csr_write(S_CMD, 16'd4);
    csr_read(S_STAT, v); check("R7 busy low in accept cycle", {16'h0, v}, 32'h0);
    @(posedge clk); #1;
    csr_read(S_STAT, v); check("R7 busy high next edge", {16'h0, v}, 32'h2);
    wait_frames(base + 1);
    csr_read(S_STAT, v); check("R7 busy low at last rise", {16'h0, v}, 32'h0);
    csr_write(S_CMD, 16'd0);

    // R6 read frame
    csr_write(S_ADDR, 16'h0203);
    push(1, 5'd3, 5'd2, 16'h1C3A, 32, "R6 read");
    base = frames_seen;
    csr_write(S_CMD, 16'd2);
    wait_frames(base + 1);
    csr_read(S_RD, v); check("R6 read data", {16'h0, v}, 32'h1C3A);
    csr_write(S_CMD, 16'd0);

    // R8 rearm rule
    push(1, 5'd3, 5'd2, 16'h0F0F, 32, "R8 read");
    base = frames_seen;
    csr_write(S_CMD, 16'd2);
    wait_frames(base + 1);
    csr_write(S_CMD, 16'd4);
    @(posedge clk); #1;
    csr_read(S_STAT, v); check("R8 not armed busy", {16'h0, v}, 32'h0);
    repeat (300) @(posedge clk); #1;
    csr_read(S_STAT, v); check("R8 still idle", {16'h0, v}, 32'h0);
    check("R8 no frame", frames_seen, base + 1);
    csr_read(S_RD, v); check("R8 read data kept", {16'h0, v}, 32'h0F0F);
    csr_write(S_CMD, 16'd0);
    push(0, 5'd3, 5'd2, 16'hBEEF, 32, "R8 write after zero");
    base = frames_seen;
    csr_write(S_CMD, 16'd4);
    wait_frames(base + 1);
    csr_write(S_CMD, 16'd0);

    // R5 preamble skip
    csr_write(S_CTRL, 16'h0104);
    csr_write(S_WD, 16'h00F1);
    push(0, 5'd3, 5'd2, 16'h00F1, 0, "R5 no preamble");
    base = frames_seen;
    csr_write(S_CMD, 16'd4);
    wait_frames(base + 1);
    csr_write(S_CMD, 16'd0);
    csr_write(S_CTRL, 16'd4);

    // R9 priority
    push(1, 5'd3, 5'd2, 16'h5555, 32, "R9 read wins");
    base = frames_seen;
    csr_write(S_CMD, 16'd6);
    wait_frames(base + 1);
    csr_read(S_RD, v); check("R9 read data", {16'h0, v}, 32'h5555);
    csr_write(S_CMD, 16'd0);

    // R10 scan
    csr_write(S_ADDR, 16'h0101);
    push(1, 5'd1, 5'd1, 16'h0004, 32, "R10 scan 1");
    push(1, 5'd1, 5'd1, 16'h0000, 32, "R10 scan 2");
    push(1, 5'd1, 5'd1, 16'h0004, 32, "R10 scan 3");
    base = frames_seen;
    csr_write(S_CMD, 16'd1);
    @(posedge clk); #1;
    csr_read(S_STAT, v); check("R10 busy and invalid", {16'h0, v}, 32'h6);
    wait_frames(base + 1);
    csr_read(S_STAT, v); check("R10 valid after first", {16'h0, v}, 32'h2);
    csr_read(S_RD, v);   check("R10 data 1", {16'h0, v}, 32'h0004);
    wait_frames(base + 2);
    csr_read(S_STAT, v); check("R10 link fail", {16'h0, v}, 32'h3);
    csr_read(S_RD, v);   check("R10 data 2", {16'h0, v}, 32'h0000);
    csr_write(S_CMD, 16'd0);
    wait_frames(base + 3);
    csr_read(S_STAT, v); check("R10 stopped", {16'h0, v}, 32'h0);
    csr_read(S_RD, v);   check("R10 data 3", {16'h0, v}, 32'h0004);
    repeat (600) @(posedge clk); #1;
    check("R10 no extra frame", frames_seen, base + 3);
    check("R10 scoreboard empty", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule